// File: doc/BRIEF.md
# Trace-Back Survivor Memory for a Four-State Viterbi Decoder

This block is the survivor store and trace-back path of a hard-decision Viterbi decoder. The code is rate 1/2 with constraint length 3 and generators 7 and 5 (octal). An external add-compare-select stage hands over one decision vector per trellis step. The vector has one bit per state, and each bit says which of that state's two predecessors won. The block writes the whole vector into one row of a 16-row circular bank. In the same cycle it walks back 15 trellis steps through the stored decisions and emits one decoded bit.

Stored rows are never moved. Each accepted vector enables exactly one row register and every other row holds, so the bank behaves as a clock-gated memory rather than a shifting path register. The walk always begins in one fixed state. No path-metric comparison is needed, because after 15 steps the survivors of all states have merged. The incoming vector is forwarded into the walk as the newest step, so a decoded bit leaves one clock after the vector that completes its 15-step window.

Top module: `svm_traceback`

## Requirements
- R1: While the synchronous active-low reset is asserted, the next clock edge drives `dec_valid_o` and `dec_bit_o` to 0 and clears the fill history, so the count of accepted vectors restarts at zero.
- R2: `dec_valid_o` is high for one cycle after each accepted vector from the 16th accepted vector after reset onwards, and low after the first 15.
- R3: The bit shown with a valid output that follows the vector of trellis step n is the source bit of step n-15. For a clean channel this means the source stream reappears 15 accepted vectors late, one clock after the vector that completes it.
- R4: When `dv_valid_i` is low, `dv_bits_i` has no effect: nothing is stored, `dec_valid_o` is low in the next cycle and `dec_bit_o` keeps its value. `dec_bit_o` changes only together with a valid output.
- R5: Each accepted vector is written whole into one row of the 16-row bank at the write pointer. The pointer then advances by one modulo 16 and no other row changes, so decoding stays correct after any number of wraps.
- R6: Bit s of a decision vector belongs to state s, whose most significant bit is its newest input bit. A 1 selects predecessor ((s<<1)&3)|1 and a 0 selects ((s<<1)&3). The decoded bit is the most significant bit of the state reached after 15 steps.
- R7: The walk begins in state 0 at the incoming vector and uses no metric search. With 15 vectors of 4'b1010 followed by 4'b0001, the 16th output is 1. Starting in any other state would give 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Synchronous reset, active low |
| dv_valid_i | input | 1 | Decision vector strobe |
| dv_bits_i | input | 4 | Decision bit per state, bit s for state s |
| dec_bit_o | output | 1 | Decoded bit, held between valid outputs |
| dec_valid_o | output | 1 | High for one cycle when `dec_bit_o` carries a new bit |

## Verification
Each accepted vector produces its response at the very next rising edge. `dec_valid_o` and `dec_bit_o` both come from a single register fed from the write cycle, and the bit refers to the source bit 15 accepted vectors earlier. The bench drives on the falling edge, lets one rising edge pass, and compares both outputs at the following falling edge. Its queue model indexes the expected bit by the count of accepted vectors, so idle cycles shift nothing. Idle cycles carry random garbage on the decision bits and are checked for an unchanged bit and a low flag. Two directed patterns pin down the bit encoding and the fixed start state independently of any metric model.

// File: rtl/svm_pkg.sv
`timescale 1ns/1ps
// svm_pkg: shared trellis constants, types and the predecessor rule.
// Assumes a rate-1/2 code whose state holds the last CONSTR_LEN-1 input
// bits with the newest bit in the most significant position.
package svm_pkg;

    localparam int unsigned CONSTR_LEN = 3;
    localparam int unsigned STATE_W    = CONSTR_LEN - 1;
    localparam int unsigned N_STATES   = 1 << STATE_W;

    typedef logic [STATE_W-1:0]  st_t;
    typedef logic [N_STATES-1:0] dvec_t;

    // Predecessor of state s when its decision bit is d: drop the newest
    // bit, shift the rest up, and append the decision as the oldest bit.
    function automatic st_t pred_state(input st_t s, input logic d);
        return {s[STATE_W-2:0], d};
    endfunction

endpackage

// File: rtl/svm_wr_ctrl.sv
`timescale 1ns/1ps
// svm_wr_ctrl: circular write pointer, one-hot row enables and fill flag.
// Assumes ROWS is a power of two so the pointer wraps by overflow, and
// DEPTH < ROWS. primed_o rises once DEPTH vectors are already stored.
module svm_wr_ctrl #(
    parameter  int unsigned ROWS  = 16,
    parameter  int unsigned DEPTH = 15,
    localparam int unsigned PTR_W = $clog2(ROWS),
    localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             push_i,
    output logic [PTR_W-1:0] ptr_o,
    output logic [ROWS-1:0]  row_we_o,
    output logic             primed_o
);

    logic [PTR_W-1:0] ptr_q;
    logic [CNT_W-1:0] fill_q;
    logic             full;

    assign full = (fill_q == CNT_W'(DEPTH));

    // Advance the write pointer by one row per accepted vector.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            ptr_q <= '0;
        end else if (push_i) begin
            ptr_q <= ptr_q + PTR_W'(1);
        end
    end

    // Count stored vectors until a full trace window exists, then saturate.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            fill_q <= '0;
        end else if (push_i && !full) begin
            fill_q <= fill_q + CNT_W'(1);
        end
    end

    // Decode one enable per row; only the addressed row sees the write.
    for (genvar r = 0; r < ROWS; r++) begin : g_we
        assign row_we_o[r] = push_i && (ptr_q == PTR_W'(r));
    end

    assign ptr_o    = ptr_q;
    assign primed_o = full;

endmodule

// File: rtl/svm_row_bank.sv
`timescale 1ns/1ps
// svm_row_bank: ROWS independent decision-row registers. Each row has its
// own enable, which stands for a gated clock; rows are never shifted.
// Assumes at most one enable is high in any cycle.
module svm_row_bank
    import svm_pkg::*;
#(
    parameter int unsigned ROWS = 16
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [ROWS-1:0]    row_we_i,
    input  dvec_t              row_d_i,
    output dvec_t [ROWS-1:0]   bank_o
);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        dvec_t row_q;

        // Capture the incoming vector only when this row is addressed.
        always_ff @(posedge clk_i) begin
            if (!rst_ni) begin
                row_q <= '0;
            end else if (row_we_i[r]) begin
                row_q <= row_d_i;
            end
        end

        assign bank_o[r] = row_q;
    end

endmodule

// File: rtl/svm_trace.sv
`timescale 1ns/1ps
// svm_trace: combinational trace-back over DEPTH trellis steps.
// Step 0 reads the incoming vector; step k reads the row written k
// vectors ago (ptr_i - k). Starts from the fixed state START_STATE and
// returns the newest-bit position of the state reached at the end.
// Assumes DEPTH < ROWS and ROWS a power of two.
module svm_trace
    import svm_pkg::*;
#(
    parameter  int unsigned ROWS        = 16,
    parameter  int unsigned DEPTH       = 15,
    parameter  int unsigned START_STATE = 0,
    localparam int unsigned PTR_W       = $clog2(ROWS)
) (
    input  logic [PTR_W-1:0] ptr_i,
    input  dvec_t            new_row_i,
    input  dvec_t [ROWS-1:0] bank_i,
    output logic             bit_o
);

    st_t  [DEPTH:0]   walk;
    logic [DEPTH-1:0] step_dec;

    assign walk[0] = st_t'(START_STATE);

    for (genvar k = 0; k < DEPTH; k++) begin : g_step
        if (k == 0) begin : g_new
            // Newest step comes straight from the vector being written.
            assign step_dec[k] = new_row_i[walk[k]];
        end else begin : g_old
            logic [PTR_W-1:0] idx;
            // Older steps read the row stored k vectors earlier.
            assign idx         = ptr_i - PTR_W'(k);
            assign step_dec[k] = bank_i[idx][walk[k]];
        end
        // Move one step back in time along the survivor.
        assign walk[k+1] = pred_state(walk[k], step_dec[k]);
    end

    assign bit_o = walk[DEPTH][STATE_W-1];

endmodule

// File: rtl/svm_traceback.sv
`timescale 1ns/1ps
// svm_traceback: survivor memory with single-row writes and a fixed-start
// trace-back. Each accepted decision vector goes into one bank row; in the
// same cycle a DEPTH-step walk yields the bit of DEPTH steps earlier, which
// is registered on the outputs. Assumes ROWS is a power of two > DEPTH.
module svm_traceback
    import svm_pkg::*;
#(
    parameter int unsigned ROWS        = 16,
    parameter int unsigned DEPTH       = 15,
    parameter int unsigned START_STATE = 0
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                dv_valid_i,
    input  logic [N_STATES-1:0] dv_bits_i,
    output logic                dec_bit_o,
    output logic                dec_valid_o
);

    localparam int unsigned PTR_W = $clog2(ROWS);

    logic [PTR_W-1:0] wr_ptr;
    logic [ROWS-1:0]  row_we;
    logic             primed;
    dvec_t [ROWS-1:0] bank_q;
    logic             trace_bit;
    logic             dec_bit_q;
    logic             dec_valid_q;

    svm_wr_ctrl #(
        .ROWS  (ROWS),
        .DEPTH (DEPTH)
    ) i_wr_ctrl (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .push_i   (dv_valid_i),
        .ptr_o    (wr_ptr),
        .row_we_o (row_we),
        .primed_o (primed)
    );

    svm_row_bank #(
        .ROWS (ROWS)
    ) i_row_bank (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .row_we_i (row_we),
        .row_d_i  (dv_bits_i),
        .bank_o   (bank_q)
    );

    svm_trace #(
        .ROWS        (ROWS),
        .DEPTH       (DEPTH),
        .START_STATE (START_STATE)
    ) i_trace (
        .ptr_i     (wr_ptr),
        .new_row_i (dv_bits_i),
        .bank_i    (bank_q),
        .bit_o     (trace_bit)
    );

    // Register the decoded bit only when a full window has just completed.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dec_bit_q <= 1'b0;
        end else if (dv_valid_i && primed) begin
            dec_bit_q <= trace_bit;
        end
    end

    // Pulse the output flag once per accepted vector after the fill.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            dec_valid_q <= 1'b0;
        end else begin
            dec_valid_q <= dv_valid_i && primed;
        end
    end

    assign dec_bit_o   = dec_bit_q;
    assign dec_valid_o = dec_valid_q;

endmodule

// File: rtl/svm_chk.sv
`timescale 1ns/1ps
// svm_chk: temporal checks on svm_traceback, bound to every instance.
// Watches the ports plus the write pointer and the row bank.
module svm_chk
    import svm_pkg::*;
#(
    parameter  int unsigned ROWS  = 16,
    parameter  int unsigned DEPTH = 15,
    localparam int unsigned PTR_W = $clog2(ROWS),
    localparam int unsigned CNT_W = $clog2(DEPTH + 2)
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic             dv_valid_i,
    input logic             dec_bit_i,
    input logic             dec_valid_i,
    input logic [PTR_W-1:0] ptr_i,
    input dvec_t [ROWS-1:0] bank_i
);

    logic             armed_q;
    logic [CNT_W-1:0] seen_q;
    dvec_t [ROWS-1:0] prev_q;
    logic [ROWS-1:0]  chg;

    // Mark that the previous edge was taken outside reset.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) armed_q <= 1'b0;
        else         armed_q <= 1'b1;
    end

    // Count accepted vectors independently, saturating past the window.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            seen_q <= '0;
        end else if (dv_valid_i && (seen_q != CNT_W'(DEPTH + 1))) begin
            seen_q <= seen_q + CNT_W'(1);
        end
    end

    // Keep last cycle's bank to spot which rows changed.
    always_ff @(posedge clk_i) begin
        prev_q <= bank_i;
    end

    for (genvar r = 0; r < ROWS; r++) begin : g_chg
        assign chg[r] = (bank_i[r] != prev_q[r]);
    end

    // R2: a valid output only once more than DEPTH vectors were accepted.
    a_r2_valid_after_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dec_valid_i |-> (seen_q == CNT_W'(DEPTH + 1)));

    // R2: every accepted vector beyond the fill produces a valid output.
    a_r2_valid_per_vector: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && $past(dv_valid_i) && (seen_q == CNT_W'(DEPTH + 1))) |-> dec_valid_i);

    // R4: an idle input cycle leaves the flag low and the bit unchanged.
    a_r4_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !$past(dv_valid_i)) |-> (!dec_valid_i && $stable(dec_bit_i)));

    // R5: only the row addressed on the previous edge may have changed.
    a_r5_single_row: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> ((chg & ~(ROWS'(1) << $past(ptr_i))) == '0));

    // R5: no row changes after an idle cycle.
    a_r5_idle_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !$past(dv_valid_i)) |-> (chg == '0));

    // R5: the pointer steps by one per accepted vector and holds otherwise.
    a_r5_ptr_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        armed_q |-> (ptr_i == ($past(ptr_i) + PTR_W'($past(dv_valid_i)))));

    // R4: the decoded bit only moves together with a valid output.
    a_r4_bit_moves_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (armed_q && !dec_valid_i) |-> $stable(dec_bit_i));

endmodule

bind svm_traceback svm_chk #(
    .ROWS  (ROWS),
    .DEPTH (DEPTH)
) i_svm_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dv_valid_i  (dv_valid_i),
    .dec_bit_i   (dec_bit_o),
    .dec_valid_i (dec_valid_o),
    .ptr_i       (wr_ptr),
    .bank_i      (bank_q)
);

// File: tb/test_svm_traceback.sv
`timescale 1ns/1ps
// test_svm_traceback: encoder plus behavioural add-compare-select model
// feed the block; a queue indexed by accepted-vector count predicts outputs.
module test_svm_traceback;

    localparam int LAT = 15;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       dv_valid;
    logic [3:0] dv_bits;
    logic       dec_bit;
    logic       dec_valid;

    int checks = 0;
    int errors = 0;

    int expq[$];
    int n_in;
    int exp_b;
    int exp_v;
    int pm[4];
    logic [1:0] enc_st;

    always #2.5 clk = ~clk;

    svm_traceback i_svm_traceback (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .dv_valid_i  (dv_valid),
        .dv_bits_i   (dv_bits),
        .dec_bit_o   (dec_bit),
        .dec_valid_o (dec_valid)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    // R1: hold reset, then confirm cleared outputs and restart the model.
    task automatic do_reset();
        rst_n    = 1'b0;
        dv_valid = 1'b0;
        dv_bits  = 4'h0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1", "valid", int'(dec_valid), 0);
        check("R1", "bit", int'(dec_bit), 0);
        rst_n = 1'b1;
        n_in  = 0;
        expq.delete();
        exp_b  = 0;
        exp_v  = 0;
        pm     = '{0, 64, 64, 64};
        enc_st = 2'b00;
    endtask

    // One cycle of stimulus; eb is the bit that must emerge LAT vectors on.
    task automatic step(input bit v, input logic [3:0] vec, input int eb, input string req);
        string rq;
        dv_valid = v;
        dv_bits  = vec;
        @(posedge clk);
        if (v) begin
            if (n_in >= LAT) begin
                exp_v = 1;
                exp_b = expq[n_in - LAT];
            end else begin
                exp_v = 0;
            end
            expq.push_back(eb);
            n_in++;
        end else begin
            exp_v = 0;
        end
        @(negedge clk);
        rq = (exp_v != 0) ? req : (v ? "R2" : "R4");
        check(rq, "valid", int'(dec_valid), exp_v);
        check(rq, "bit", int'(dec_bit), exp_b);
    endtask

    // Reference add-compare-select for error-free symbols (R6 encoding).
    task automatic acs(input int r0, input int r1, output logic [3:0] dv);
        int npm[4];
        int mn;
        for (int s = 0; s < 4; s++) begin
            int u  = s >> 1;
            int p0 = (s << 1) & 3;
            int p1 = p0 | 1;
            int c0 = ((u ^ (p0 >> 1) ^ (p0 & 1)) != r0) + ((u ^ (p0 & 1)) != r1);
            int c1 = ((u ^ (p1 >> 1) ^ (p1 & 1)) != r0) + ((u ^ (p1 & 1)) != r1);
            int m0 = pm[p0] + c0;
            int m1 = pm[p1] + c1;
            if (m1 < m0) begin
                dv[s]  = 1'b1;
                npm[s] = m1;
            end else begin
                dv[s]  = 1'b0;
                npm[s] = m0;
            end
        end
        mn = npm[0];
        for (int s = 1; s < 4; s++) if (npm[s] < mn) mn = npm[s];
        for (int s = 0; s < 4; s++) pm[s] = npm[s] - mn;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [3:0] dv;
        int u;
        int r0;
        int r1;
        string rq;

        do_reset();

        // R6: all-ones decisions lead state 0 to 1 then 3, so output is 1.
        for (int i = 0; i < 24; i++) begin
            step(1'b1, 4'b1111, 1, "R6");
            if (i % 5 == 0) step(1'b0, 4'($urandom), 0, "R4");
        end

        // R1: reset while the bit is 1 must clear both outputs.
        do_reset();

        // R7: fixed start in state 0 reaches state 1, then 3; other starts give 0.
        for (int i = 0; i < LAT; i++) step(1'b1, 4'b1010, (i == 0) ? 1 : 0, "R7");
        step(1'b1, 4'b0001, 0, "R7");

        do_reset();

        // R3, R5: random source through encoder and reference ACS, with gaps.
        for (int i = 0; i < 2500; i++) begin
            rq = (i < 200) ? "R3" : "R5";
            if ($urandom_range(0, 4) == 0) begin
                step(1'b0, 4'($urandom), 0, "R4");
            end else begin
                u  = int'($urandom_range(0, 1));
                r0 = u ^ int'(enc_st[1]) ^ int'(enc_st[0]);
                r1 = u ^ int'(enc_st[0]);
                enc_st = {1'(u), enc_st[1]};
                acs(r0, r1, dv);
                step(1'b1, dv, u, rq);
            end
        end

        finish_run();
    end

endmodule